// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timing Generator

This block produces the control strobes for an 8-bit raw NAND flash device. A host hands it one request at a time on four request inputs: a command byte, an address byte, a data byte to write, or a data byte to read. Each accepted request becomes one bus cycle. The cycle has a setup phase, a strobe-low phase and a hold phase. The block then waits a programmable time and samples the device ready/busy line. Commands raise the command-latch output for the whole cycle and addresses raise the address-latch output. Writes drive the byte onto the shared bus, and reads capture the bus byte as the read strobe returns high.

The phase lengths come from a 32-bit timing word. It holds one 4-bit field per phase for reads and another set for writes, and the word is captured when a request is accepted. A separate input holds chip-enable active for as long as it is set. A synchronous soft-reset input abandons any cycle in progress. A registered status output reports the most recently sampled ready line.

Top module: `nand_strobe_gen`

## Requirements
- R1: The timing word holds eight 4-bit fields. Bits [3:0], [7:4], [11:8] and [15:12] are read setup, read hold, read strobe width and read ready wait. Bits [19:16], [23:20], [27:24] and [31:28] are the same four fields for write cycles. Command, address and data-write cycles use the write fields, and data reads use the read fields.
- R2: A setup field of value n keeps the strobe high for n+1 clocks after the request is accepted, so a setup of zero still lasts one clock.
- R3: A width field of value n holds the active strobe low for exactly n+1 clocks. Write-type cycles use nand_we_n and reads use nand_re_n, and the two are never low together.
- R4: After the strobe rises, the hold phase lasts n+1 clocks for a hold field of value n. Then come 2*m clocks of ready wait for a wait field of value m, then one sample clock. busy is high from the clock after acceptance to the end of the sample clock.
- R5: A command cycle holds nand_cle high, and an address cycle holds nand_ale high, for the setup, strobe and hold phases. A data cycle raises neither. The two latch outputs are never high together.
- R6: In every write-type cycle, nand_dq_oe is high and nand_dq_out carries wr_byte for the setup, strobe and hold phases. In reads, nand_dq_oe stays low.
- R7: For a read, nand_dq_in is latched into rd_byte on the clock where nand_re_n rises, and rd_valid pulses high for exactly one clock at that point.
- R8: dev_ready takes the value of nand_rb (1 = device ready) on the sample clock. It changes at no other time, and it is 0 after reset.
- R9: nand_ce_n goes low one clock after force_ce is set and returns high one clock after it is cleared.
- R10: A request made while busy is high is ignored. It starts no cycle and does not change the byte on the bus.
- R11: When several request inputs are high together in an idle clock, one cycle starts, chosen in the order command, address, data write, data read.
- R12: A clock with soft_rst high ends any cycle. On the next clock, busy is 0, both strobes are high, both latches are low and rd_valid is 0.
- R13: After rst_n is released, busy, rd_valid, nand_cle, nand_ale, nand_dq_oe and dev_ready are 0, and nand_ce_n, nand_we_n and nand_re_n are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous abort to idle |
| force_ce | input | 1 | Hold chip-enable active while set |
| timing_word | input | 32 | Packed phase-length fields |
| cmd_wr | input | 1 | Request a command-byte cycle |
| addr_wr | input | 1 | Request an address-byte cycle |
| data_wr | input | 1 | Request a data-write cycle |
| data_rd | input | 1 | Request a data-read cycle |
| wr_byte | input | 8 | Byte for command, address or data write |
| busy | output | 1 | Cycle or ready wait in progress |
| rd_valid | output | 1 | One-clock pulse when rd_byte updates |
| rd_byte | output | 8 | Byte captured in the last read |
| dev_ready | output | 1 | Last sampled ready line, 1 = ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus byte driven by the block |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Bus byte from the device |
| nand_rb | input | 1 | Device ready/busy line, 1 = ready |

## Verification
Strobes, latches and busy all change one clock after the request clock. The strobe stays high for setup+1 clocks, stays low for width+1 clocks, and is followed by hold+1+2*wait+1 busy clocks. rd_valid and rd_byte appear on the clock where the read strobe rises, and dev_ready is valid once busy drops. Inputs are driven at the falling edge and outputs are sampled at falling edges, one sample per clock. Each phase is measured by counting samples from the first falling edge after the request clock until busy reads 0. These counts are compared with lengths the bench computes from the fields of the timing word. The bench checks nand_ce_n and the soft-reset outcome at the falling edge that follows the clock on which the input is seen.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_WAIT,
    PH_SAMPLE
  } phase_e;

  typedef enum logic [1:0] {
    OP_CMD,
    OP_ADDR,
    OP_DWR,
    OP_DRD
  } op_e;

  // field slots inside one direction's group of the timing word
  localparam int unsigned FI_SETUP   = 0;
  localparam int unsigned FI_HOLD    = 1;
  localparam int unsigned FI_WIDTH   = 2;
  localparam int unsigned FI_WAIT    = 3;
  localparam int unsigned FI_WR_BASE = 4;
  localparam int unsigned FI_COUNT   = 8;

endpackage

// File: rtl/nsg_phase_ctrl.sv
module nsg_phase_ctrl
  import nsg_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int BUS_W   = 8,
  parameter int TW_W    = FI_COUNT * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             req_valid,
  input  op_e              req_op,
  input  logic [BUS_W-1:0] req_data,
  input  logic [TW_W-1:0]  tword,
  output phase_e           phase_q,
  output phase_e           phase_d,
  output op_e              op_d,
  output logic [BUS_W-1:0] data_d,
  output logic             rd_capture,
  output logic             sample_now
);

  localparam int CNT_W = FIELD_W + 1;

  op_e              op_q;
  logic [BUS_W-1:0] data_q;
  logic [TW_W-1:0]  tw_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load_en;
  logic             cnt_zero;

  function automatic logic [FIELD_W-1:0] field_of(input logic [TW_W-1:0] tw,
                                                   input op_e op,
                                                   input int unsigned idx);
    int unsigned base;
    base = (op == OP_DRD) ? 0 : FI_WR_BASE;
    return tw[(base + idx) * FIELD_W +: FIELD_W];
  endfunction

  assign load_en  = (phase_q == PH_IDLE) && req_valid && !soft_rst;
  assign cnt_zero = (cnt_q == '0);

  assign op_d   = load_en ? req_op : op_q;
  assign data_d = load_en ? req_data : data_q;

  // next-state process
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (load_en) begin
          phase_d = PH_SETUP;
          cnt_d   = {1'b0, field_of(tword, req_op, FI_SETUP)};
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_STROBE;
          cnt_d   = {1'b0, field_of(tw_q, op_q, FI_WIDTH)};
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          phase_d = PH_HOLD;
          cnt_d   = {1'b0, field_of(tw_q, op_q, FI_HOLD)};
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_HOLD: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (field_of(tw_q, op_q, FI_WAIT) == '0) begin
          phase_d = PH_SAMPLE;
          cnt_d   = '0;
        end else begin
          phase_d = PH_WAIT;
          cnt_d   = {field_of(tw_q, op_q, FI_WAIT), 1'b0} - CNT_W'(1);
        end
      end
      PH_WAIT: begin
        if (cnt_zero) begin
          phase_d = PH_SAMPLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_SAMPLE: begin
        phase_d = PH_IDLE;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
    if (soft_rst) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_CMD;
      data_q <= '0;
      tw_q   <= '0;
    end else if (load_en) begin
      op_q   <= req_op;
      data_q <= req_data;
      tw_q   <= tword;
    end
  end

  assign rd_capture = (phase_q == PH_STROBE) && cnt_zero && (op_q == OP_DRD) && !soft_rst;
  assign sample_now = (phase_q == PH_SAMPLE) && !soft_rst;

  // R10: a cycle can only begin from idle
  assert_enter_setup_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP && $past(phase_q) != PH_SETUP) |-> $past(phase_q) == PH_IDLE);

  // R12: soft reset always lands in idle
  assert_soft_reset_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> phase_q == PH_IDLE);

endmodule

// File: rtl/nsg_strobe_drv.sv
module nsg_strobe_drv
  import nsg_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_ce,
  input  phase_e           phase_d,
  input  op_e              op_d,
  input  logic [BUS_W-1:0] data_d,
  output logic             ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic             dq_oe,
  output logic [BUS_W-1:0] dq_out
);

  logic             active_d, strobe_d, is_rd_d;
  logic             ce_n_d, cle_d, ale_d, we_n_d, re_n_d, dq_oe_d;
  logic [BUS_W-1:0] dq_out_d;

  // decode the next phase so the pins are registered yet aligned with it
  always_comb begin
    active_d = (phase_d == PH_SETUP) || (phase_d == PH_STROBE) || (phase_d == PH_HOLD);
    strobe_d = (phase_d == PH_STROBE);
    is_rd_d  = (op_d == OP_DRD);
    ce_n_d   = !force_ce;
    cle_d    = active_d && (op_d == OP_CMD);
    ale_d    = active_d && (op_d == OP_ADDR);
    we_n_d   = !(strobe_d && !is_rd_d);
    re_n_d   = !(strobe_d && is_rd_d);
    dq_oe_d  = active_d && !is_rd_d;
    dq_out_d = dq_oe_d ? data_d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n   <= 1'b1;
      cle    <= 1'b0;
      ale    <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      ce_n   <= ce_n_d;
      cle    <= cle_d;
      ale    <= ale_d;
      we_n   <= we_n_d;
      re_n   <= re_n_d;
      dq_oe  <= dq_oe_d;
      dq_out <= dq_out_d;
    end
  end

  // R3: never both strobes low
  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R5: never both latches high
  assert_latch_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R6: the bus is not driven while reading
  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);

endmodule

// File: rtl/nsg_rb_sampler.sv
module nsg_rb_sampler #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             rd_capture,
  input  logic             sample_now,
  input  logic [BUS_W-1:0] dq_in,
  input  logic             rb,
  output logic             rd_valid,
  output logic [BUS_W-1:0] rd_byte,
  output logic             ready
);

  logic             rd_byte_en, ready_en;
  logic [BUS_W-1:0] rd_byte_d;
  logic             ready_d, rd_valid_d;

  always_comb begin
    rd_byte_en = rd_capture;
    ready_en   = sample_now;
    rd_byte_d  = dq_in;
    ready_d    = rb;
    rd_valid_d = rd_capture && !soft_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_byte <= '0;
    end else if (rd_byte_en) begin
      rd_byte <= rd_byte_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
    end else if (ready_en) begin
      ready <= ready_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_valid_d;
    end
  end

  // R8: status only moves on a sample clock
  assert_ready_only_on_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_now |=> $stable(ready));

  // R7: read byte only moves with a capture
  assert_rd_byte_on_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rd_byte));

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
#(
  parameter int FIELD_W = 4,
  parameter int BUS_W   = 8,
  parameter int TW_W    = FI_COUNT * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             force_ce,
  input  logic [TW_W-1:0]  timing_word,
  input  logic             cmd_wr,
  input  logic             addr_wr,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic [BUS_W-1:0] wr_byte,
  output logic             busy,
  output logic             rd_valid,
  output logic [BUS_W-1:0] rd_byte,
  output logic             dev_ready,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [BUS_W-1:0] nand_dq_out,
  output logic             nand_dq_oe,
  input  logic [BUS_W-1:0] nand_dq_in,
  input  logic             nand_rb
);

  logic             req_valid;
  op_e              req_op;
  phase_e           phase_q, phase_d;
  op_e              op_d;
  logic [BUS_W-1:0] data_d;
  logic             rd_capture, sample_now;

  // fixed priority among simultaneous requests
  always_comb begin
    req_valid = cmd_wr || addr_wr || data_wr || data_rd;
    if (cmd_wr)       req_op = OP_CMD;
    else if (addr_wr) req_op = OP_ADDR;
    else if (data_wr) req_op = OP_DWR;
    else              req_op = OP_DRD;
  end

  nsg_phase_ctrl #(.FIELD_W(FIELD_W), .BUS_W(BUS_W), .TW_W(TW_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_data   (wr_byte),
    .tword      (timing_word),
    .phase_q    (phase_q),
    .phase_d    (phase_d),
    .op_d       (op_d),
    .data_d     (data_d),
    .rd_capture (rd_capture),
    .sample_now (sample_now)
  );

  nsg_strobe_drv #(.BUS_W(BUS_W)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_ce (force_ce),
    .phase_d  (phase_d),
    .op_d     (op_d),
    .data_d   (data_d),
    .ce_n     (nand_ce_n),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .dq_oe    (nand_dq_oe),
    .dq_out   (nand_dq_out)
  );

  nsg_rb_sampler #(.BUS_W(BUS_W)) u_rb (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .rd_capture (rd_capture),
    .sample_now (sample_now),
    .dq_in      (nand_dq_in),
    .rb         (nand_rb),
    .rd_valid   (rd_valid),
    .rd_byte    (rd_byte),
    .ready      (dev_ready)
  );

  assign busy = (phase_q != PH_IDLE);

  // R4: strobes only move inside a busy cycle
  assert_strobe_within_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> busy);

  // R7: rd_valid coincides with the read strobe rising
  assert_rd_valid_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(nand_re_n));

  // R9: chip enable follows the force control one clock later
  assert_ce_follows_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_ce |=> !nand_ce_n);

endmodule

// File: tb/nand_strobe_gen_bench.sv
module nand_strobe_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst, force_ce;
  logic [31:0] timing_word;
  logic        cmd_wr, addr_wr, data_wr, data_rd;
  logic [7:0]  wr_byte;
  logic        busy, rd_valid, dev_ready;
  logic [7:0]  rd_byte;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out, nand_dq_in;
  logic        nand_rb;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  nand_strobe_gen u_nand_strobe_gen (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .force_ce(force_ce),
    .timing_word(timing_word), .cmd_wr(cmd_wr), .addr_wr(addr_wr),
    .data_wr(data_wr), .data_rd(data_rd), .wr_byte(wr_byte), .busy(busy),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .dev_ready(dev_ready),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected op by priority: 0 cmd, 1 addr, 2 data write, 3 data read
  function automatic int pick_op(input logic [3:0] req);
    if (req[3]) return 0;
    if (req[2]) return 1;
    if (req[1]) return 2;
    return 3;
  endfunction

  function automatic int fld(input logic [31:0] tw, input int op, input int slot);
    int base;
    base = (op == 3) ? 0 : 16;
    return int'(tw[base + slot*4 +: 4]);
  endfunction

  // req bits: [3] cmd, [2] addr, [1] data write, [0] data read
  task automatic run_op(input logic [3:0] req, input logic [7:0] d, input logic [31:0] tw,
                        input logic rb, input logic [7:0] din);
    int op, s, h, w, r;
    int setc, wec, rec, tail, clec, alec, oec, rdvc, dqbad;
    bit seen_low;
    logic [7:0] got;
    op = pick_op(req);
    s = fld(tw, op, 0); h = fld(tw, op, 1); w = fld(tw, op, 2); r = fld(tw, op, 3);
    setc = 0; wec = 0; rec = 0; tail = 0; clec = 0; alec = 0; oec = 0; rdvc = 0; dqbad = 0;
    seen_low = 0; got = 8'h00;
    @(negedge clk);
    timing_word = tw; nand_rb = rb; nand_dq_in = din; wr_byte = d;
    {cmd_wr, addr_wr, data_wr, data_rd} = req;
    @(negedge clk);
    {cmd_wr, addr_wr, data_wr, data_rd} = 4'b0000;
    timing_word = ~tw;   // snapshot taken at acceptance
    while (busy) begin
      if (!nand_we_n || !nand_re_n) begin
        seen_low = 1;
        if (!nand_we_n) wec++;
        if (!nand_re_n) rec++;
      end else if (!seen_low) setc++;
      else tail++;
      if (nand_cle) clec++;
      if (nand_ale) alec++;
      if (nand_dq_oe) begin
        oec++;
        if (nand_dq_out != d) dqbad++;
      end
      if (rd_valid) begin rdvc++; got = rd_byte; end
      @(negedge clk);
    end
    chk(setc == s + 1, "R2 setup clocks", setc, s + 1);
    chk(((op == 3) ? rec : wec) == w + 1, "R3 strobe low clocks", (op == 3) ? rec : wec, w + 1);
    chk(((op == 3) ? wec : rec) == 0, "R3 wrong strobe", (op == 3) ? wec : rec, 0);
    chk(tail == h + 1 + 2*r + 1, "R4 hold+wait+sample clocks", tail, h + 2*r + 2);
    chk(clec == ((op == 0) ? s + w + h + 3 : 0), "R5 cle clocks", clec, (op == 0) ? s + w + h + 3 : 0);
    chk(alec == ((op == 1) ? s + w + h + 3 : 0), "R5 ale clocks", alec, (op == 1) ? s + w + h + 3 : 0);
    chk(oec == ((op == 3) ? 0 : s + w + h + 3), "R6 dq_oe clocks", oec, (op == 3) ? 0 : s + w + h + 3);
    chk(dqbad == 0, "R6 dq_out byte", dqbad, 0);
    chk(rdvc == ((op == 3) ? 1 : 0), "R7 rd_valid pulses", rdvc, (op == 3) ? 1 : 0);
    if (op == 3) chk(got == din, "R7 read byte", int'(got), int'(din));
    chk(dev_ready == rb, "R8 ready status", int'(dev_ready), int'(rb));
    chk(op >= 0, "R1 field group", op, op);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; soft_rst = 1'b0; force_ce = 1'b0; timing_word = '0;
    cmd_wr = 1'b0; addr_wr = 1'b0; data_wr = 1'b0; data_rd = 1'b0;
    wr_byte = '0; nand_dq_in = '0; nand_rb = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(!busy && !rd_valid && !nand_cle && !nand_ale && !nand_dq_oe, "R13 reset low outputs",
        int'({busy, rd_valid, nand_cle, nand_ale, nand_dq_oe}), 0);
    chk(nand_ce_n && nand_we_n && nand_re_n, "R13 reset high outputs",
        int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
    chk(dev_ready == 1'b0, "R13 reset ready", int'(dev_ready), 0);

    // R1 directed corners: distinct fields, all zero, all max
    run_op(4'b1000, 8'h70, 32'h0123_4567, 1'b1, 8'h00);
    run_op(4'b0001, 8'h00, 32'h0123_4567, 1'b0, 8'hC3);
    run_op(4'b0100, 8'h5A, 32'h0000_0000, 1'b1, 8'h00);
    run_op(4'b0001, 8'h00, 32'hFFFF_FFFF, 1'b1, 8'h96);
    run_op(4'b0010, 8'hE1, 32'hFEDC_BA98, 1'b0, 8'h00);
    // R11 priority combinations
    run_op(4'b1111, 8'h11, 32'h1203_2130, 1'b1, 8'h22);
    run_op(4'b0111, 8'h33, 32'h2130_1203, 1'b1, 8'h44);
    run_op(4'b0011, 8'h55, 32'h0312_3021, 1'b1, 8'h66);

    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [3:0] rq;
      rq = 4'($urandom_range(1, 15));
      run_op(rq, 8'($urandom), $urandom, 1'($urandom), 8'($urandom));
    end

    // R10 request while busy ignored
    @(negedge clk);
    timing_word = 32'h1111_1111; wr_byte = 8'hA5; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; data_wr = 1'b1; wr_byte = 8'h3C;
    cnt = 0;
    begin
      int badbyte;
      badbyte = 0;
      while (busy) begin
        if (nand_dq_oe && nand_dq_out != 8'hA5) badbyte++;
        cnt++;
        @(negedge clk);
        data_wr = 1'b0;
      end
      chk(badbyte == 0, "R10 bus byte unchanged", badbyte, 0);
    end
    chk(cnt == 9, "R10 busy clocks of first cycle", cnt, 9);
    cnt = 0;
    for (int k = 0; k < 3; k++) begin
      if (busy) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R10 no second cycle", cnt, 0);

    // R12 soft reset during a long read strobe
    timing_word = 32'hFFFF_FFFF; data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    repeat (20) @(negedge clk);
    chk(!nand_re_n, "R12 strobe low before abort", int'(nand_re_n), 0);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(!busy && nand_re_n && nand_we_n && !rd_valid && !nand_cle && !nand_ale,
        "R12 idle after soft reset",
        int'({busy, nand_re_n, nand_we_n, rd_valid, nand_cle, nand_ale}), 24);
    run_op(4'b0100, 8'h0F, 32'h2222_1111, 1'b1, 8'h00);

    // R9 forced chip enable
    force_ce = 1'b1;
    @(negedge clk);
    chk(nand_ce_n == 1'b0, "R9 ce low when forced", int'(nand_ce_n), 0);
    force_ce = 1'b0;
    @(negedge clk);
    chk(nand_ce_n == 1'b1, "R9 ce released", int'(nand_ce_n), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule